// File: doc/BRIEF.md
# Polar Parity-Check Bit Generator

This block builds the input vector of a polar encoder one position at a time. Each position comes with a class code: frozen, information or parity-check. Frozen positions take the value zero. Information positions take the next bit of the incoming payload stream. Parity-check positions take a value that depends on the data: the modulo-2 sum of the earlier non-parity-check bits of the same codeword whose distance from the current position is a multiple of five.

The sums come from a five-cell cyclic register that turns one place per position. A frozen or information bit is folded into the head cell before the register turns. At a parity-check position the head cell is read out, left as it is and turned onward. Parity-check bits therefore never feed later parity checks. The register is cleared after the last position of each codeword.

Upstream logic decides where the parity-check positions go, and the polar transform runs downstream. Both are outside this block. An information position with no payload bit available is flagged on the output beat of that position.

Top module: `pcc_gen_top`

## Requirements
- R1: After reset, and until the first stepped position, `u_vld` and `underflow` are low and `u_idx` is 0.
- R2: A position of class 2'b00 (frozen) or 2'b11 (reserved, handled as frozen) outputs 0, does not raise `info_take`, and adds nothing to later parity sums.
- R3: A position of class 2'b01 (information) with `info_vld` high outputs `info_bit` and raises `info_take` in the same cycle it is stepped.
- R4: A position of class 2'b10 (parity-check) at index k outputs the XOR of every earlier bit i of the same codeword with (k-i) mod 5 = 0, where i is not itself a parity-check position.
- R5: Parity-check outputs are excluded from every later parity sum. A parity-check bit whose only same-residue predecessors are parity checks, or which has no predecessors, outputs 0.
- R6: A position stepped by `pos_en` in cycle t appears on `u_vld`/`u_bit` in cycle t+1. Positions are numbered 0 to N_POS-1 in stepping order, `u_idx` carries that number, and `u_last` marks N_POS-1.
- R7: After position N_POS-1 the next stepped position is index 0, and no bit of the finished codeword enters any parity sum of the new one.
- R8: An information position stepped with `info_vld` low outputs 0 with `underflow` high on the same beat and counts as a 0 in later parity sums.
- R9: A cycle without `pos_en` produces no output beat and advances neither the index nor the cyclic register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pos_en | input | 1 | Step one position this cycle |
| pos_kind | input | 2 | Class of the stepped position (00 frozen, 01 information, 10 parity-check, 11 frozen) |
| info_bit | input | 1 | Next payload bit |
| info_vld | input | 1 | `info_bit` holds a bit |
| info_take | output | 1 | Payload bit consumed this cycle |
| u_vld | output | 1 | Output beat present |
| u_bit | output | 1 | Value of the position |
| u_idx | output | IDX_W | Position index of the beat |
| u_last | output | 1 | Beat is the final position of the codeword |
| underflow | output | 1 | Information position lacked a payload bit |

## Verification
A wrong register cell or a wrong rotation shows up only at parity-check positions. It can stay hidden for up to five positions, until the next parity check of the affected residue. The stimulus therefore places parity checks both early and late, next to each other, and behind other parity checks of the same residue. A register that is not cleared between codewords shows up as a wrong value at the first parity-check beat of the following codeword. A slip of the index counter shows up as a `u_idx` mismatch on the very next beat.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic [1:0] {
        KIND_FROZEN = 2'b00,
        KIND_INFO   = 2'b01,
        KIND_PARITY = 2'b10,
        KIND_RSVD   = 2'b11
    } pos_kind_e;

endpackage

// File: rtl/pcc_pos_counter.sv
module pcc_pos_counter #(
    parameter int N_POS = 32,
    localparam int IDX_W = (N_POS > 1) ? $clog2(N_POS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_POS - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (en) begin
            if (cnt_q.idx == LAST_IDX) cnt_d.idx = '0;
            else                       cnt_d.idx = cnt_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign idx  = cnt_q.idx;
    assign last = (cnt_q.idx == LAST_IDX);

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt_q.idx == LAST_IDX) |=> (cnt_q.idx == '0));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt_q.idx));

endmodule

// File: rtl/pcc_cyc_reg.sv
module pcc_cyc_reg #(
    parameter int SPAN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clear,
    input  logic is_parity,
    input  logic bit_in,
    output logic head
);

    typedef struct packed {
        logic [SPAN-1:0] cells;
    } ring_t;

    ring_t ring_d, ring_q;
    logic [SPAN-1:0] folded;

    always_comb begin
        ring_d = ring_q;
        folded = ring_q.cells;
        if (!is_parity) folded[0] = ring_q.cells[0] ^ bit_in;
        if (en) begin
            if (clear) ring_d.cells = '0;
            else       ring_d.cells = {folded[0], folded[SPAN-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    assign head = ring_q.cells[0];

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clear) |=> (ring_q.cells == '0));

    assert_parity_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && is_parity && !clear) |=> (ring_q.cells[SPAN-1] == $past(ring_q.cells[0])));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(ring_q.cells));

endmodule

// File: rtl/pcc_gen_top.sv
module pcc_gen_top #(
    parameter int N_POS = 32,
    parameter int SPAN  = 5,
    localparam int IDX_W = (N_POS > 1) ? $clog2(N_POS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pos_en,
    input  logic [1:0]       pos_kind,
    input  logic             info_bit,
    input  logic             info_vld,
    output logic             info_take,
    output logic             u_vld,
    output logic             u_bit,
    output logic [IDX_W-1:0] u_idx,
    output logic             u_last,
    output logic             underflow
);

    import pcc_pkg::*;

    typedef struct packed {
        logic             vld;
        logic             bitv;
        logic [IDX_W-1:0] idx;
        logic             last;
        logic             uflow;
    } beat_t;

    beat_t beat_d, beat_q;

    logic [IDX_W-1:0] cur_idx;
    logic             cur_last;
    logic             ring_head;
    logic             is_info;
    logic             is_parity;
    logic             bit_now;
    pos_kind_e        kind;

    assign kind = pos_kind_e'(pos_kind);

    pcc_pos_counter #(.N_POS(N_POS)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (pos_en),
        .idx  (cur_idx),
        .last (cur_last)
    );

    pcc_cyc_reg #(.SPAN(SPAN)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (pos_en),
        .clear    (cur_last),
        .is_parity(is_parity),
        .bit_in   (bit_now),
        .head     (ring_head)
    );

    always_comb begin
        is_info   = (kind == KIND_INFO);
        is_parity = (kind == KIND_PARITY);
        unique case (kind)
            KIND_INFO:   bit_now = info_vld & info_bit;
            KIND_PARITY: bit_now = ring_head;
            default:     bit_now = 1'b0;
        endcase

        beat_d       = beat_q;
        beat_d.vld   = pos_en;
        if (pos_en) begin
            beat_d.bitv  = bit_now;
            beat_d.idx   = cur_idx;
            beat_d.last  = cur_last;
            beat_d.uflow = is_info & ~info_vld;
        end else begin
            beat_d.uflow = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) beat_q <= '0;
        else        beat_q <= beat_d;
    end

    assign info_take = pos_en & is_info & info_vld;
    assign u_vld     = beat_q.vld;
    assign u_bit     = beat_q.bitv;
    assign u_idx     = beat_q.idx;
    assign u_last    = beat_q.last;
    assign underflow = beat_q.uflow;

    assert_frozen_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_en && (pos_kind == 2'b00 || pos_kind == 2'b11)) |=> (u_vld && !u_bit));

    assert_info_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_en && pos_kind == 2'b01 && info_vld) |=> (u_bit == $past(info_bit)));

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pos_en |=> u_vld);

    assert_no_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pos_en |=> !u_vld);

    assert_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_en && pos_kind == 2'b01 && !info_vld) |=> (underflow && !u_bit));

    assert_uflow_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> u_vld);

endmodule

// File: tb/pcc_gen_top_tb_top.sv
module pcc_gen_top_tb_top;

    localparam int N_POS = 32;
    localparam int IDX_W = $clog2(N_POS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pos_en = 1'b0;
    logic [1:0]       pos_kind = 2'b00;
    logic             info_bit = 1'b0;
    logic             info_vld = 1'b0;
    logic             info_take;
    logic             u_vld;
    logic             u_bit;
    logic [IDX_W-1:0] u_idx;
    logic             u_last;
    logic             underflow;

    always #4 clk = ~clk;

    pcc_gen_top #(.N_POS(N_POS), .SPAN(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .pos_en(pos_en), .pos_kind(pos_kind),
        .info_bit(info_bit), .info_vld(info_vld), .info_take(info_take),
        .u_vld(u_vld), .u_bit(u_bit), .u_idx(u_idx), .u_last(u_last),
        .underflow(underflow)
    );

    typedef struct {
        int idx;
        bit val;
        bit uflow;
        bit last;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    bit hist_bit[N_POS];
    bit hist_pc[N_POS];
    int mdl_idx = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic bit next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // Drives one position and pushes the expected beat (R2..R8 model)
    task automatic drive_pos(input logic [1:0] kind, input bit vld, input bit b);
        exp_t e;
        bit   v;
        bit   pc;
        @(negedge clk);
        pos_en = 1'b1; pos_kind = kind; info_vld = vld; info_bit = b;
        v = 1'b0; pc = 1'b0;
        e.uflow = 1'b0;
        if (kind == 2'b01) begin
            v = vld ? b : 1'b0;
            e.uflow = !vld;
        end else if (kind == 2'b10) begin
            pc = 1'b1;
            for (int i = 0; i < mdl_idx; i++)
                if (((mdl_idx - i) % 5 == 0) && !hist_pc[i]) v ^= hist_bit[i];
        end
        e.idx = mdl_idx; e.val = v; e.last = (mdl_idx == N_POS - 1);
        hist_bit[mdl_idx] = v; hist_pc[mdl_idx] = pc;
        exp_q.push_back(e);
        #1;
        if (kind == 2'b01) chk(info_take == vld, "R3 info_take", int'(info_take), int'(vld));
        else               chk(info_take == 1'b0, "R2 info_take", int'(info_take), 0);
        if (mdl_idx == N_POS - 1) mdl_idx = 0;
        else                      mdl_idx++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pos_en = 1'b0; info_vld = 1'b0;
        end
    endtask

    // pat 0: frozen head, 3 parity checks; 1: no parity, reserved codes;
    // 2: chained/adjacent parity checks; 3: underflow feeding a parity check
    function automatic logic [1:0] kind_of(input int pat, input int i);
        case (pat)
            0: begin
                if (i == 10 || i == 17 || i == 23) return 2'b10;
                if (i < 6) return 2'b00;
                return 2'b01;
            end
            1: begin
                if (i == 3 || i == 8) return 2'b11;
                if (i < 2) return 2'b00;
                return 2'b01;
            end
            2: begin
                if (i == 2 || i == 4 || i == 7 || i == 9 || i == 14 || i == 15 || i == 20) return 2'b10;
                return 2'b01;
            end
            default: begin
                if (i == 10 || i == 11) return 2'b10;
                if (i < 3) return 2'b00;
                return 2'b01;
            end
        endcase
    endfunction

    task automatic run_cw(input int pat, input bit ones, input bit gaps);
        for (int i = 0; i < N_POS; i++) begin
            bit b;
            bit v;
            b = ones ? 1'b1 : next_rand();
            v = !(pat == 3 && (i == 5 || i == 6));
            drive_pos(kind_of(pat, i), v, b);
            if (gaps && (i % 3 == 1)) idle(2);
        end
    endtask

    // Monitor: compares each output beat with the scoreboard (R6, R9)
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && u_vld) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected beat", int'(u_idx), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(int'(u_idx) == e.idx, "R6 u_idx", int'(u_idx), e.idx);
                    chk(u_last == e.last, "R6 u_last", int'(u_last), int'(e.last));
                    chk(underflow == e.uflow, "R8 underflow", int'(underflow), int'(e.uflow));
                    chk(u_bit == e.val, "R2/R3/R4/R5/R7 u_bit", int'(u_bit), int'(e.val));
                end
            end else if (rst_n) begin
                chk(underflow == 1'b0, "R8 underflow without beat", int'(underflow), 0);
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        chk(u_vld == 1'b0, "R1 u_vld", int'(u_vld), 0);
        chk(underflow == 1'b0, "R1 underflow", int'(underflow), 0);
        chk(u_idx == '0, "R1 u_idx", int'(u_idx), 0);

        run_cw(0, 1'b0, 1'b0);   // R4 with three checks
        run_cw(1, 1'b0, 1'b0);   // R2 reserved code, no parity
        run_cw(2, 1'b1, 1'b0);   // R5 parity skips parity
        run_cw(0, 1'b1, 1'b0);   // R7 fresh codeword after all-ones one
        idle(3);                 // R9 idle cycles
        run_cw(3, 1'b1, 1'b1);   // R8 underflow with gaps (R9)
        run_cw(0, 1'b0, 1'b0);   // R7 again after underflow codeword
        idle(4);
        chk(exp_q.size() == 0, "R6 pending beats", exp_q.size(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule